// File: doc/BRIEF.md
# Scanline Fetch Address Generator

This block walks a display frame one scanline at a time. For every line it gives the byte address in display memory where that line's data starts, the horizontal pixel shift to apply to it, and a flag that says whether the split-screen region has begun. A frame begins with a one-cycle frame-start pulse. That pulse loads the start address and the panning value. Each later one-cycle advance strobe closes the current line and moves on to the next one.

The address moves in whole rows. A row can be shown on several consecutive scanlines, set by the repeat count. Two low mode bits also gate which rows step the address forward. A 10-bit compare value sets the last line of the upper screen part. After that line the address restarts at zero, so a second region of memory fills the rest of the frame. When the split-panning enable is on, horizontal panning is also cancelled for the lower part.

Top module: `crtc_scan_addr`

## Requirements
- R1: While reset is active and after it, before any frame start, `line_addr` is 0, `pel_shift` is 0 and `split_active` is 0.
- R2: A frame start loads `line_addr` with {start_hi, start_lo} × 4, clears `split_active` and reloads the pel value from `pel_reg`. These outputs are visible in the cycle after the pulse.
- R3: On an advance that closes the last repeat of a row, the address grows by `offset_reg` × 8 only if (row & m) == m, where m = `crtc_mode` XOR 3 and row counts rows from 0 in the frame. The row then increments.
- R4: With `scan_repeat` = N, each row occupies N+1 scanlines before the row counter and the address move on.
- R5: The compare value is {maxscan_reg[6], overflow_reg[4], lcmp_lo}. The advance that closes the line whose index (0 for the first line of the frame) equals that value sets `line_addr` to 0 and raises `split_active` for the rest of the frame.
- R6: If `pan_split_en` is 1 at that advance, the pel value becomes the neutral value 8 for the rest of the frame, so the applied shift is 0. If it is 0, the pel value is unchanged.
- R7: `pel_shift` equals the low 3 bits of the pel value when `depth_le8` is 1, and 0 when it is 0.
- R8: In a cycle with neither a frame start nor an advance, `line_addr`, `split_active` and the internal position do not change.
- R9: The address is ADDR_W (18) bits wide and wraps modulo 2^ADDR_W.
- R10: A frame start in the same cycle as an advance takes priority. The advance is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Frame-start pulse |
| line_adv | input | 1 | Scanline advance strobe |
| start_hi | input | 8 | Start address, high byte |
| start_lo | input | 8 | Start address, low byte |
| offset_reg | input | 8 | Row pitch in units of 8 bytes |
| lcmp_lo | input | 8 | Compare value bits 7:0 |
| overflow_reg | input | 8 | Bit 4 is compare bit 8 |
| maxscan_reg | input | 8 | Bit 6 is compare bit 9 |
| crtc_mode | input | 2 | Row gating bits |
| scan_repeat | input | REP_W | Extra scanlines per row |
| pel_reg | input | 4 | Horizontal pel panning value |
| pan_split_en | input | 1 | Cancel panning below the split |
| depth_le8 | input | 1 | Pixel depth is 8 bits or less |
| line_addr | output | ADDR_W | Byte address of the current line |
| pel_shift | output | 3 | Applied pixel shift |
| split_active | output | 1 | Split region reached |

## Verification
The bench uses the default widths: an 18-bit address, a 5-bit repeat count and an 11-bit line counter. The 11-bit counter lets a frame run past line 1023 without the line counter wrapping back onto a compare match. The 18-bit address lets a start near 0xFFFF plus a large pitch run through the address wrap. The 5-bit repeat field allows rows spread over many lines, so the repeat and the mode gating interact within frames of a few hundred lines. Compare values with bit 8 or bit 9 set are placed at lines 261 and 512, so both upper compare bits are reached.

// File: rtl/crtc_scan_addr_pkg.sv
package crtc_scan_addr_pkg;
    // Pel value that shifts no pixel in any mode once its bit 3 is dropped
    localparam logic [3:0] PEL_NEUTRAL = 4'd8;
    localparam int CMP_W = 10;

    // Rows that step the address: (row & m) == m, m = mode ^ 3
    function automatic logic row_steps(input logic [1:0] row, input logic [1:0] mode);
        logic [1:0] m;
        m = mode ^ 2'b11;
        return (row & m) == m;
    endfunction
endpackage

// File: rtl/crtc_scan_cfg.sv
module crtc_scan_cfg
    import crtc_scan_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [7:0]        start_hi,
    input  logic [7:0]        start_lo,
    input  logic [7:0]        offset_reg,
    input  logic [7:0]        lcmp_lo,
    input  logic [7:0]        overflow_reg,
    input  logic [7:0]        maxscan_reg,
    output logic [ADDR_W-1:0] start_byte,
    output logic [ADDR_W-1:0] line_step,
    output logic [CMP_W-1:0]  cmp_line
);
    logic [17:0] start_raw;
    logic [10:0] step_raw;

    always_comb begin
        start_raw  = {start_hi, start_lo, 2'b00};
        step_raw   = {offset_reg, 3'b000};
        start_byte = ADDR_W'(start_raw);
        line_step  = ADDR_W'(step_raw);
        cmp_line   = {maxscan_reg[6], overflow_reg[4], lcmp_lo};
    end
endmodule

// File: rtl/crtc_scan_pel.sv
module crtc_scan_pel (
    input  logic [3:0] pel_q,
    input  logic       depth_le8,
    output logic [2:0] pel_shift
);
    always_comb begin
        pel_shift = depth_le8 ? pel_q[2:0] : 3'd0;
    end
endmodule

// File: rtl/crtc_scan_addr.sv
module crtc_scan_addr
    import crtc_scan_addr_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int REP_W  = 5,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              line_adv,
    input  logic [7:0]        start_hi,
    input  logic [7:0]        start_lo,
    input  logic [7:0]        offset_reg,
    input  logic [7:0]        lcmp_lo,
    input  logic [7:0]        overflow_reg,
    input  logic [7:0]        maxscan_reg,
    input  logic [1:0]        crtc_mode,
    input  logic [REP_W-1:0]  scan_repeat,
    input  logic [3:0]        pel_reg,
    input  logic              pan_split_en,
    input  logic              depth_le8,
    output logic [ADDR_W-1:0] line_addr,
    output logic [2:0]        pel_shift,
    output logic              split_active
);
    localparam int ROW_W = 2;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ROW_W-1:0]  row;
        logic [REP_W-1:0]  rep;
        logic [LINE_W-1:0] line;
        logic [3:0]        pel;
        logic              split;
    } scan_state_t;

    scan_state_t s_d, s_q;

    logic [ADDR_W-1:0] start_byte;
    logic [ADDR_W-1:0] line_step;
    logic [CMP_W-1:0]  cmp_line;

    crtc_scan_cfg #(.ADDR_W(ADDR_W)) cfg_i (
        .start_hi     (start_hi),
        .start_lo     (start_lo),
        .offset_reg   (offset_reg),
        .lcmp_lo      (lcmp_lo),
        .overflow_reg (overflow_reg),
        .maxscan_reg  (maxscan_reg),
        .start_byte   (start_byte),
        .line_step    (line_step),
        .cmp_line     (cmp_line)
    );

    crtc_scan_pel pel_i (
        .pel_q     (s_q.pel),
        .depth_le8 (depth_le8),
        .pel_shift (pel_shift)
    );

    always_comb begin
        s_d = s_q;
        if (sof) begin
            s_d.addr  = start_byte;
            s_d.row   = '0;
            s_d.rep   = scan_repeat;
            s_d.line  = '0;
            s_d.pel   = pel_reg;
            s_d.split = 1'b0;
        end else if (line_adv) begin
            // row bookkeeping: last repeat of a row closes it
            if (s_q.rep == '0) begin
                if (row_steps(s_q.row, crtc_mode)) begin
                    s_d.addr = s_q.addr + line_step;
                end
                s_d.row = s_q.row + 1'b1;
                s_d.rep = scan_repeat;
            end else begin
                s_d.rep = s_q.rep - 1'b1;
            end
            // split compare overrides the row step
            if (s_q.line == LINE_W'(cmp_line)) begin
                s_d.addr  = '0;
                s_d.split = 1'b1;
                if (pan_split_en) begin
                    s_d.pel = PEL_NEUTRAL;
                end
            end
            if (s_q.line != LINE_MAX) begin
                s_d.line = s_q.line + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_addr    = s_q.addr;
    assign split_active = s_q.split;
endmodule

// File: rtl/crtc_scan_addr_chk.sv
module crtc_scan_addr_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sof,
    input logic              line_adv,
    input logic [7:0]        start_hi,
    input logic [7:0]        start_lo,
    input logic [3:0]        pel_reg,
    input logic              depth_le8,
    input logic [ADDR_W-1:0] line_addr,
    input logic [2:0]        pel_shift,
    input logic              split_active
);
    assert_frame_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (line_addr == ADDR_W'({$past(start_hi), $past(start_lo), 2'b00})) && !split_active);

    assert_frame_pel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (!depth_le8 || pel_shift == $past(pel_reg[2:0])));

    assert_split_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(split_active) |-> (line_addr == '0));

    assert_split_on_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(split_active) |-> ($past(line_adv) && !$past(sof)));

    assert_wide_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !depth_le8 |-> (pel_shift == 3'd0));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && !line_adv) |=> ($stable(line_addr) && $stable(split_active)));
endmodule

bind crtc_scan_addr crtc_scan_addr_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (sof),
    .line_adv     (line_adv),
    .start_hi     (start_hi),
    .start_lo     (start_lo),
    .pel_reg      (pel_reg),
    .depth_le8    (depth_le8),
    .line_addr    (line_addr),
    .pel_shift    (pel_shift),
    .split_active (split_active)
);

// File: tb/crtc_scan_addr_tb_top.sv
module crtc_scan_addr_tb_top;
    localparam int ADDR_W = 18;
    localparam int REP_W  = 5;
    localparam int LINE_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 1'b0, line_adv = 1'b0;
    logic [7:0] start_hi = '0, start_lo = '0, offset_reg = '0, lcmp_lo = '0;
    logic [7:0] overflow_reg = '0, maxscan_reg = '0;
    logic [1:0] crtc_mode = '0;
    logic [REP_W-1:0] scan_repeat = '0;
    logic [3:0] pel_reg = '0;
    logic pan_split_en = 1'b0, depth_le8 = 1'b1;
    logic [ADDR_W-1:0] line_addr;
    logic [2:0] pel_shift;
    logic split_active;

    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    crtc_scan_addr #(.ADDR_W(ADDR_W), .REP_W(REP_W), .LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sof(sof), .line_adv(line_adv),
        .start_hi(start_hi), .start_lo(start_lo), .offset_reg(offset_reg),
        .lcmp_lo(lcmp_lo), .overflow_reg(overflow_reg), .maxscan_reg(maxscan_reg),
        .crtc_mode(crtc_mode), .scan_repeat(scan_repeat), .pel_reg(pel_reg),
        .pan_split_en(pan_split_en), .depth_le8(depth_le8),
        .line_addr(line_addr), .pel_shift(pel_shift), .split_active(split_active)
    );

    // reference model state
    logic [ADDR_W-1:0] m_addr = '0;
    logic [1:0]        m_row = '0;
    int                m_rep = 0;
    int                m_line = 0;
    logic [3:0]        m_pel = '0;
    logic              m_split = 1'b0;

    function automatic int cmp_value();
        return {maxscan_reg[6], overflow_reg[4], lcmp_lo};
    endfunction

    function automatic logic [2:0] exp_shift();
        return depth_le8 ? m_pel[2:0] : 3'd0;
    endfunction

    function automatic logic steps(input logic [1:0] row);
        logic [1:0] m;
        m = crtc_mode ^ 2'b11;
        return (row & m) == m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " addr"}, 32'(line_addr), 32'(m_addr));
        check({tag, " pel"}, 32'(pel_shift), 32'(exp_shift()));
        check({tag, " split"}, 32'(split_active), 32'(m_split));
    endtask

    task automatic model_sof();
        m_addr  = ADDR_W'({start_hi, start_lo, 2'b00});
        m_row   = '0;
        m_rep   = int'(scan_repeat);
        m_line  = 0;
        m_pel   = pel_reg;
        m_split = 1'b0;
    endtask

    task automatic model_adv();
        if (m_rep == 0) begin
            if (steps(m_row)) m_addr = m_addr + ADDR_W'({offset_reg, 3'b000});
            m_row = m_row + 2'd1;
            m_rep = int'(scan_repeat);
        end else begin
            m_rep--;
        end
        if (m_line == cmp_value()) begin
            m_addr  = '0;
            m_split = 1'b1;
            if (pan_split_en) m_pel = 4'd8;
        end
        if (m_line < (1 << LINE_W) - 1) m_line++;
    endtask

    task automatic do_sof(input string tag);
        sof = 1'b1;
        model_sof();
        @(negedge clk);
        sof = 1'b0;
        check_all(tag);
    endtask

    task automatic do_adv(input string tag);
        line_adv = 1'b1;
        model_adv();
        @(negedge clk);
        line_adv = 1'b0;
        check_all(tag);
    endtask

    task automatic set_cfg(input logic [15:0] st, input logic [7:0] off, input int cmp,
                           input logic [1:0] mode, input int rep, input logic [3:0] pel,
                           input logic sp, input logic d8);
        {start_hi, start_lo} = st;
        offset_reg   = off;
        lcmp_lo      = cmp[7:0];
        overflow_reg = {3'b0, cmp[8], 4'b0};
        maxscan_reg  = {1'b0, cmp[9], 6'b0};
        crtc_mode    = mode;
        scan_repeat  = REP_W'(rep);
        pel_reg      = pel;
        pan_split_en = sp;
        depth_le8    = d8;
    endtask

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        check_all("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2 R3 R5 R6 R7: mode 3 steps every row, split at line 5 with panning cancel
        set_cfg(16'h1234, 8'h28, 5, 2'd3, 0, 4'd3, 1'b1, 1'b1);
        do_sof("R2 load");
        for (int i = 0; i < 9; i++) do_adv("R3 R5 R6 every row");

        // R6: split without panning cancel keeps the pel value; R7 mode 2 every other row
        set_cfg(16'h0100, 8'h10, 4, 2'd2, 0, 4'd5, 1'b0, 1'b1);
        do_sof("R2 reload");
        for (int i = 0; i < 8; i++) do_adv("R3 R6 no cancel");

        // R3 R4: mode 0 (every fourth row) with repeated scanlines
        set_cfg(16'h0040, 8'h03, 1023, 2'd0, 2, 4'd7, 1'b0, 1'b1);
        do_sof("R2 mode0");
        for (int i = 0; i < 30; i++) do_adv("R4 repeat");

        // R7: wide pixel depth suppresses the shift
        set_cfg(16'h0002, 8'h01, 1023, 2'd1, 1, 4'd6, 1'b0, 1'b0);
        do_sof("R7 wide depth");
        for (int i = 0; i < 4; i++) do_adv("R7 wide depth");

        // R8: idle cycles hold the outputs
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_all("R8 idle hold");
        end
        do_adv("R8 after idle");

        // R9: wrap of the address
        set_cfg(16'hFFFF, 8'hFF, 1023, 2'd3, 0, 4'd0, 1'b0, 1'b1);
        do_sof("R9 start");
        do_adv("R9 wrap");
        check("R9 wrap value", 32'(line_addr), 32'h007F4);
        do_adv("R9 wrap again");

        // R10: frame start wins over an advance
        set_cfg(16'h0800, 8'h04, 1023, 2'd3, 0, 4'd2, 1'b0, 1'b1);
        do_sof("R10 setup");
        do_adv("R10 setup adv");
        start_hi = 8'h09;
        line_adv = 1'b1;
        do_sof("R10 priority");
        line_adv = 1'b0;
        check("R10 value", 32'(line_addr), 32'h2400);

        // R5: compare bit 9 (line 512)
        set_cfg(16'h0000, 8'h01, 512, 2'd3, 0, 4'd1, 1'b1, 1'b1);
        do_sof("R5 bit9");
        for (int i = 0; i < 515; i++) do_adv("R5 bit9 compare");

        // R5: compare bit 8 plus low bits (line 261), must not hit at line 5
        set_cfg(16'h0010, 8'h02, 261, 2'd3, 0, 4'd4, 1'b1, 1'b1);
        do_sof("R5 bit8");
        for (int i = 0; i < 264; i++) do_adv("R5 bit8 compare");

        // random frames
        for (int f = 0; f < 40; f++) begin
            set_cfg(16'($urandom), 8'($urandom), (($urandom % 8) == 0) ? 1023 : int'($urandom % 40),
                    2'($urandom), int'($urandom % 4), 4'($urandom), 1'($urandom), 1'($urandom));
            do_sof("R2 random frame");
            for (int l = 0; l < 20 + int'($urandom % 40); l++) begin
                if (($urandom % 5) == 0) begin
                    @(negedge clk);
                    check_all("R8 random idle");
                end
                do_adv("R3 R4 R5 random line");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule